// File: doc/BRIEF.md
# Waveform Sample Buffer Controller

The block sits between a host that loads output samples and a converter sample clock that drains them. The samples live in an inferred single-port-per-side RAM whose installed depth is fixed at build time. The host sets an active size in power-of-two steps, starting at four samples. Only that many entries take part in buffering.

Two storage disciplines are offered. In open mode the buffer is a first-in first-out queue and each sample is consumed once. In circular mode a loaded waveform is replayed endlessly and never discarded. Independently of that, output is either continuous, where every sample tick takes a sample when one is available, or burst, where a trigger releases exactly one pass of the active size and the block then waits. The trigger can come from a software strobe or an external pin.

Typical use: set the mode and size, load the samples, then let the sample tick (and, in burst mode, the trigger) pace the channel sequencer through `rdValid`/`rdData`.

Top module: `wavebuf_top`

## Requirements
- R1: After reset `empty`=1, `full`=0, `level`=0, `rdValid`=0 and `burstBusy`=0.
- R2: In open mode, samples leave in the order they were written. A sample tick accepted at one rising edge gives `rdValid`=1 with the sample on `rdData` after that same edge, and `rdValid` stays 0 otherwise.
- R3: In open mode, `level` counts stored samples. `empty` is 1 exactly when `level`=0, and `full` is 1 exactly when `level` equals the active size. A host write while `full` is dropped and leaves `level` unchanged.
- R4: The active size is 4 shifted left by `sizeSel` (`sizeSel`=0 gives 4, 1 gives 8). Any `sizeSel` that would exceed the installed depth selects the installed depth.
- R5: In circular mode, writes fill the buffer up to the active size and then are dropped. Playback runs only while the buffer is full. The read position wraps from the last active entry to the first, so the loaded sequence repeats, and `level` stays at the active size.
- R6: In continuous mode, a sample tick on each of consecutive cycles yields a sample on each of consecutive cycles, including across the circular wrap, with no idle cycle.
- R7: In burst mode, no sample is output until a trigger (`swTrig` or `extTrig` high for a cycle) is seen. After the trigger, exactly active-size samples are output on the following ticks, with `burstBusy`=1 while the pass runs. Then output stops.
- R8: A trigger that arrives while `burstBusy`=1 is ignored and does not lengthen or restart the pass.
- R9: Any change of `sizeSel` (after clamping), `circMode` or `burstMode` clears `level` and both positions and ends a running burst. A write or read presented in the cycle of the change is dropped.
- R10: In open mode, a sample tick while `empty` produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| circMode | input | 1 | 1 = circular replay, 0 = open queue |
| burstMode | input | 1 | 1 = triggered one-pass output, 0 = continuous |
| sizeSel | input | SEL_W | Active size exponent: size = 4 << sizeSel |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | DATA_W | Host write sample |
| sampleTick | input | 1 | Converter sample clock strobe (one cycle) |
| swTrig | input | 1 | Software burst trigger |
| extTrig | input | 1 | External burst trigger |
| rdValid | output | 1 | Sample present on rdData this cycle |
| rdData | output | DATA_W | Sample toward the channel sequencer |
| level | output | ADDR_W+1 | Stored sample count |
| empty | output | 1 | No stored sample |
| full | output | 1 | Level equals active size |
| burstBusy | output | 1 | Burst pass in progress |

## Verification
The hardest situation to reach is a trigger arriving in the middle of a running burst, in circular mode. The same situation must also be followed by a second burst, to show that the pass length and the wrap position were not disturbed. The stimulus loads a full circular buffer and fires a software trigger. It then raises the external trigger while samples are already flowing, counts the samples and matches their values against the loaded sequence. Open-mode behaviour is covered by a long random mix of writes and ticks against a queue model in the bench. That mix includes simultaneous writes and reads at the full and empty edges.

// File: rtl/wavebuf_pkg.sv
package wavebuf_pkg;
  typedef struct packed {
    logic wrStb;   // commit host sample at write position
    logic rdStb;   // fetch sample at read position
    logic clrStb;  // return both positions to zero
  } bufStrobes_t;
endpackage

// File: rtl/wavebuf_dp.sv
module wavebuf_dp
  import wavebuf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       stb,
  input  logic [ADDR_W-1:0] idxMask,
  input  logic [DATA_W-1:0] wrData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrIdx, rdIdx;

  // positions advance modulo the active size (a power of two)
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrStb) begin
      wrIdx   <= '0;
      rdIdx   <= '0;
      rdValid <= 1'b0;
    end else begin
      if (stb.wrStb) wrIdx <= (wrIdx + 1'b1) & idxMask;
      if (stb.rdStb) rdIdx <= (rdIdx + 1'b1) & idxMask;
      rdValid <= stb.rdStb;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrStb) mem[wrIdx] <= wrData;
    if (stb.rdStb) rdData <= mem[rdIdx];
  end
endmodule

// File: rtl/wavebuf_ctrl.sv
module wavebuf_ctrl
  import wavebuf_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  sizeSel,
  input  logic              circMode,
  input  logic              burstMode,
  input  logic              hostWrEn,
  input  logic              sampleTick,
  input  logic              swTrig,
  input  logic              extTrig,
  output bufStrobes_t       stb,
  output logic [ADDR_W-1:0] idxMask,
  output logic [ADDR_W:0]   level,
  output logic              empty,
  output logic              full,
  output logic              burstBusy
);
  localparam int MAX_SEL = ADDR_W - 2;
  localparam int CFG_W   = SEL_W + 2;

  logic [SEL_W-1:0]  sizeEff;
  logic [CFG_W-1:0]  cfgNow, cfgQ;
  logic              cfgChg;
  logic [ADDR_W:0]   activeSize;
  logic [ADDR_W:0]   remain;
  logic              canWr, canRd, dataOk, runOk, trig;

  always_comb begin
    sizeEff    = (sizeSel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sizeSel;
    cfgNow     = {sizeEff, circMode, burstMode};
    cfgChg     = (cfgNow != cfgQ);
    activeSize = (ADDR_W+1)'(4) << sizeEff;
    idxMask    = activeSize[ADDR_W-1:0] - 1'b1;
    empty      = (level == '0);
    full       = (level == activeSize);
    trig       = swTrig | extTrig;
    dataOk     = circMode ? full : !empty;
    runOk      = burstMode ? burstBusy : 1'b1;
    canWr      = hostWrEn && !full && !cfgChg;
    canRd      = sampleTick && dataOk && runOk && !cfgChg;
    stb.wrStb  = canWr;
    stb.rdStb  = canRd;
    stb.clrStb = cfgChg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      cfgQ <= cfgNow;
    end
  end

  // occupancy: circular replay never consumes
  always_ff @(posedge clk) begin
    if (!rstN || cfgChg) begin
      level <= '0;
    end else if (circMode) begin
      if (canWr) level <= level + 1'b1;
    end else begin
      case ({canWr, canRd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // one-pass burst sequencer
  always_ff @(posedge clk) begin
    if (!rstN || cfgChg) begin
      burstBusy <= 1'b0;
      remain    <= '0;
    end else if (!burstBusy) begin
      if (burstMode && trig) begin
        burstBusy <= 1'b1;
        remain    <= activeSize;
      end
    end else if (canRd) begin
      remain <= remain - 1'b1;
      if (remain == (ADDR_W+1)'(1)) burstBusy <= 1'b0;
    end
  end
endmodule

// File: rtl/wavebuf_top.sv
module wavebuf_top
  import wavebuf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int SEL_W  = $clog2(ADDR_W - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              circMode,
  input  logic              burstMode,
  input  logic [SEL_W-1:0]  sizeSel,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              sampleTick,
  input  logic              swTrig,
  input  logic              extTrig,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W:0]   level,
  output logic              empty,
  output logic              full,
  output logic              burstBusy
);
  bufStrobes_t       stb;
  logic [ADDR_W-1:0] idxMask;

  wavebuf_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sizeSel(sizeSel), .circMode(circMode),
    .burstMode(burstMode), .hostWrEn(hostWrEn), .sampleTick(sampleTick),
    .swTrig(swTrig), .extTrig(extTrig), .stb(stb), .idxMask(idxMask),
    .level(level), .empty(empty), .full(full), .burstBusy(burstBusy)
  );

  wavebuf_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .idxMask(idxMask),
    .wrData(hostWrData), .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/wavebuf_chk.sv
module wavebuf_chk #(
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] sizeSel,
  input logic             circMode,
  input logic             sampleTick,
  input logic             swTrig,
  input logic             extTrig,
  input logic             rdValid,
  input logic [ADDR_W:0]  level,
  input logic             empty,
  input logic             full,
  input logic             burstBusy
);
  logic [ADDR_W:0] sizeRef;
  always_comb begin
    if (int'(sizeSel) > ADDR_W - 2) sizeRef = (ADDR_W+1)'(1) << ADDR_W;
    else                            sizeRef = (ADDR_W+1)'(4) << sizeSel;
  end

  // R2
  rd_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(sampleTick));

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(sizeSel) |-> (level <= sizeRef));

  // R3
  full_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(sizeSel) && full) |-> (level == sizeRef));

  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(empty && full));

  // R7
  burst_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burstBusy) |-> $past(swTrig || extTrig));

  // R5
  circ_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(circMode) && circMode && $stable(sizeSel) && (level < $past(level)))
      |-> (level == '0));
endmodule

bind wavebuf_top wavebuf_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rstN(rstN), .sizeSel(sizeSel), .circMode(circMode),
  .sampleTick(sampleTick), .swTrig(swTrig), .extTrig(extTrig),
  .rdValid(rdValid), .level(level), .empty(empty), .full(full),
  .burstBusy(burstBusy)
);

// File: tb/wavebuf_top_tb_top.sv
`timescale 1ns/1ps
module wavebuf_top_tb_top;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam int SEL_W  = 4;

  logic clk = 1'b0;
  logic rstN, circMode, burstMode, hostWrEn, sampleTick, swTrig, extTrig;
  logic [SEL_W-1:0]  sizeSel;
  logic [DATA_W-1:0] hostWrData;
  logic              rdValid, empty, full, burstBusy;
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W:0]   level;

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  wavebuf_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rstN(rstN), .circMode(circMode), .burstMode(burstMode),
    .sizeSel(sizeSel), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .sampleTick(sampleTick), .swTrig(swTrig), .extTrig(extTrig),
    .rdValid(rdValid), .rdData(rdData), .level(level), .empty(empty),
    .full(full), .burstBusy(burstBusy)
  );

  function automatic int sizeOf(int sel);
    if (sel > ADDR_W - 2) return 1 << ADDR_W;
    return 4 << sel;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill(int n, ref logic [DATA_W-1:0] v[$]);
    v.delete();
    hostWrEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      hostWrData = DATA_W'($urandom);
      v.push_back(hostWrData);
      step();
    end
    hostWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    logic [DATA_W-1:0] v[$];
    logic [DATA_W-1:0] q[$];
    int cnt, lvl;
    bit w, r;
    void'($urandom(32'd2718));
    rstN = 0; circMode = 0; burstMode = 0; sizeSel = '0; hostWrEn = 0;
    hostWrData = '0; sampleTick = 0; swTrig = 0; extTrig = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    step();
    // R1 reset state
    chk(empty == 1 && full == 0, "R1 flags", {empty, full}, 2);
    chk(level == 0, "R1 level", int'(level), 0);
    chk(rdValid == 0 && burstBusy == 0, "R1 valid/busy", {rdValid, burstBusy}, 0);

    // open mode, size 8 (R3, R4, R2, R6, R10)
    sizeSel = 1; step();
    fill(9, v);
    chk(level == 8, "R3/R4 level at size 8", int'(level), 8);
    chk(full == 1, "R3 full", full, 1);
    sampleTick = 1;
    for (int i = 0; i < 8; i++) begin
      step();
      chk(rdValid == 1, "R6 back-to-back valid", rdValid, 1);
      chk(rdData == v[i], "R2 order", int'(rdData), int'(v[i]));
    end
    step();
    chk(rdValid == 0, "R10 empty tick", rdValid, 0);
    chk(empty == 1, "R3 empty", empty, 1);
    sampleTick = 0;

    // open mode random mix against queue model (R2, R3)
    sizeSel = 2; step();
    q.delete(); lvl = 0;
    for (int i = 0; i < 400; i++) begin
      w = ($urandom % 2) == 0;
      r = ($urandom % 3) != 0;
      hostWrEn = w; sampleTick = r;
      hostWrData = DATA_W'($urandom);
      w = w && lvl < 16;
      r = r && lvl > 0;
      step();
      chk(rdValid == r, "R2 random valid", rdValid, r);
      if (r) begin
        chk(rdData == q[0], "R2 random data", int'(rdData), int'(q[0]));
        void'(q.pop_front());
      end
      if (w) q.push_back(hostWrData);
      lvl = lvl + int'(w) - int'(r);
      chk(int'(level) == lvl, "R3 random level", int'(level), lvl);
      chk(full == (lvl == 16) && empty == (lvl == 0), "R3 random flags",
          {full, empty}, {lvl == 16, lvl == 0});
    end
    hostWrEn = 0; sampleTick = 0;

    // circular, size 4 (R9, R5, R6)
    circMode = 1; sizeSel = 0; step();
    chk(level == 0, "R9 clear on mode change", int'(level), 0);
    fill(5, v);
    chk(level == 4, "R5 circular fill stops", int'(level), 4);
    sampleTick = 1;
    for (int i = 0; i < 10; i++) begin
      step();
      chk(rdValid == 1 && rdData == v[i % 4], "R5 R6 wrap replay",
          int'(rdData), int'(v[i % 4]));
    end
    sampleTick = 0;
    chk(level == 4, "R5 level kept", int'(level), 4);

    // burst, circular, size 8 (R7, R8)
    burstMode = 1; sizeSel = 1; step();
    fill(8, v);
    sampleTick = 1;
    cnt = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      cnt += int'(rdValid);
    end
    chk(cnt == 0, "R7 no output before trigger", cnt, 0);
    sampleTick = 0; swTrig = 1; step(); swTrig = 0;
    chk(burstBusy == 1, "R7 busy after sw trigger", burstBusy, 1);
    sampleTick = 1; cnt = 0;
    for (int i = 0; i < 12; i++) begin
      extTrig = (i == 3);
      step();
      if (rdValid) begin
        chk(rdData == v[cnt % 8], "R7 burst data", int'(rdData), int'(v[cnt % 8]));
        cnt++;
      end
    end
    extTrig = 0;
    chk(cnt == 8, "R8 mid-burst trigger ignored", cnt, 8);
    chk(burstBusy == 0, "R7 burst ends", burstBusy, 0);
    sampleTick = 0; extTrig = 1; step(); extTrig = 0;
    sampleTick = 1; cnt = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (rdValid) begin
        chk(rdData == v[cnt % 8], "R7 ext burst data", int'(rdData), int'(v[cnt % 8]));
        cnt++;
      end
    end
    chk(cnt == 8, "R7 ext burst length", cnt, 8);
    sampleTick = 0;

    // size change mid-burst (R9)
    swTrig = 1; step(); swTrig = 0;
    sampleTick = 1;
    repeat (3) step();
    sampleTick = 0; sizeSel = 0; step();
    chk(burstBusy == 0, "R9 burst ended", burstBusy, 0);
    chk(level == 0 && empty == 1, "R9 level cleared", int'(level), 0);

    // clamp at installed depth (R4)
    circMode = 0; burstMode = 0; sizeSel = 4'd15; step();
    fill(sizeOf(15) + 1, v);
    chk(int'(level) == sizeOf(15), "R4 clamp level", int'(level), sizeOf(15));
    chk(full == 1, "R4 clamp full", full, 1);

    done = 1;
    summary();
  end
endmodule